// File: doc/BRIEF.md
# Symmetric Switching-State Sequencer for a Three-Level Inverter

This block plays out one modulation period of a three-level, three-phase inverter. When a period is started it takes a triangle code, a sector number and three dwell counts, then walks through a fixed list of switching states. Each state sets every phase to +1, 0 or −1, and each state is held for a fixed share of one of the dwell counts. The list runs out to its centre and back again, so a period starts and ends on the same state. A neighbouring stage works out the dwell counts. This block only orders and times the states.

Two kinds of list are used. The two inner triangles have vertices with more redundant states, so they get a nine-state list. The two outer triangles get a seven-state list. The lists are stored for the first sector only. For any other sector the stored state is turned by 60 degrees once per sector step: the phase levels move round one place and all of them change sign.

Control is a two-state machine. The states are ST_IDLE and ST_PLAY. There are four transitions:
- GO: ST_IDLE to ST_PLAY, when a start arrives and the period has at least one cycle.
- STAY_EMPTY: ST_IDLE to ST_IDLE, when a start arrives and all three dwell counts are zero.
- ADVANCE: ST_PLAY to ST_PLAY, when a segment ends and a later segment of non-zero length remains.
- DONE: ST_PLAY to ST_IDLE, after the last cycle of the last non-empty segment.

Top module: `svm_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `busy` is 0 and all three level outputs are 0.
- R2: The machine accepts `start` only while `busy` is 0. If the dwell counts add up to N > 0, `busy` is 1 for exactly N cycles, starting in the cycle after the accepting clock edge. A start held high gives periods separated by one idle cycle.
- R3: Each level output is a 2-bit two's-complement value: 01 means +1, 00 means 0, 11 means −1. The code 10 never appears. For sector 1, triangle code 0 plays (a,b,c) = [0,−,−] [0,0,−] [0,0,0] [+,0,0] [+,+,0] [+,0,0] [0,0,0] [0,0,−] [0,−,−]. Triangle code 1 plays [0,−,−] [0,0,−] [+,0,−] [+,0,0] [+,+,0] [+,0,0] [+,0,−] [0,0,−] [0,−,−].
- R4: For sector 1, triangle code 2 plays [0,−,−] [+,−,−] [+,0,−] [+,0,0] [+,0,−] [+,−,−] [0,−,−]. Triangle code 3 plays [0,0,−] [+,0,−] [+,+,−] [+,+,0] [+,+,−] [+,0,−] [0,0,−].
- R5: Segment lengths are counted in cycles and rounded down by integer division.
  - Nine-state list: A/6, B/3, C/2, A/3, centre, A/3, C/2, B/3, A/6.
  - Seven-state list: A/4, B/2, C/2, centre, C/2, B/2, A/4.
  - The centre segment takes whatever is left of A+B+C.
- R6: Sector codes 2 to 6 apply (a,b,c) → (−b,−c,−a) to each stored state, once per step above 1. Codes 0, 1 and 7 use the stored states unchanged.
- R7: A `start`, or a change of triangle, sector or dwell inputs, has no effect on the outputs while `busy` is 1.
- R8: A segment of length zero is skipped. If all three dwell counts are zero, a start leaves `busy` at 0 and the levels unchanged.
- R9: While `busy` is 0 the levels hold their last value. Each period ends on the state it started with.
- R10: When the machine moves to the next listed segment, exactly one phase changes, and it changes by one level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Period start strobe |
| tri_code | input | 2 | Triangle within the sector, 0 to 3 |
| sector | input | 3 | Sector number, 1 to 6 |
| dwell_a | input | DW | Dwell count A |
| dwell_b | input | DW | Dwell count B |
| dwell_c | input | DW | Dwell count C |
| busy | output | 1 | High while a period plays |
| lvl_a | output | 2 | Phase a level |
| lvl_b | output | 2 | Phase b level |
| lvl_c | output | 2 | Phase c level |

## Verification
The bench builds the block with DW = 6, so dwell counts can reach their all-ones value of 63 and a whole period still takes under two hundred cycles. At that width the bench can try every triangle in every sector code. It can also try dwell counts that leave remainders under every divisor, zero-length segments, and the largest centre sum the widened counter must hold. A start is held high through whole periods, with changing inputs, to show that a running period cannot be disturbed.

// File: rtl/svm_seq_pkg.sv
package svm_seq_pkg;
    localparam int NSEG = 9;
    localparam int SEGW = 4;
    localparam int NROT = 6;

    typedef logic signed [1:0] lvl_t;
    typedef struct packed {
        lvl_t a;
        lvl_t b;
        lvl_t c;
    } trip_t;

    typedef enum logic {ST_IDLE, ST_PLAY} st_e;

    function automatic trip_t mk(int a, int b, int c);
        trip_t t;
        t.a = lvl_t'(a);
        t.b = lvl_t'(b);
        t.c = lvl_t'(c);
        return t;
    endfunction

    // first half (up to centre) of each sector-one list
    function automatic trip_t half_state(logic [1:0] tcode, logic [2:0] h);
        trip_t t;
        t = '0;
        unique case (tcode)
            2'd0: case (h)
                3'd0: t = mk(0, -1, -1);
                3'd1: t = mk(0, 0, -1);
                3'd2: t = mk(0, 0, 0);
                3'd3: t = mk(1, 0, 0);
                3'd4: t = mk(1, 1, 0);
                default: t = '0;
            endcase
            2'd1: case (h)
                3'd0: t = mk(0, -1, -1);
                3'd1: t = mk(0, 0, -1);
                3'd2: t = mk(1, 0, -1);
                3'd3: t = mk(1, 0, 0);
                3'd4: t = mk(1, 1, 0);
                default: t = '0;
            endcase
            2'd2: case (h)
                3'd0: t = mk(0, -1, -1);
                3'd1: t = mk(1, -1, -1);
                3'd2: t = mk(1, 0, -1);
                3'd3: t = mk(1, 0, 0);
                default: t = '0;
            endcase
            2'd3: case (h)
                3'd0: t = mk(0, 0, -1);
                3'd1: t = mk(1, 0, -1);
                3'd2: t = mk(1, 1, -1);
                3'd3: t = mk(1, 1, 0);
                default: t = '0;
            endcase
        endcase
        return t;
    endfunction

    // one 60-degree step: shift phases, negate all
    function automatic trip_t rot60(trip_t s);
        trip_t r;
        r.a = -s.b;
        r.b = -s.c;
        r.c = -s.a;
        return r;
    endfunction
endpackage

// File: rtl/svm_seq_split.sv
module svm_seq_split import svm_seq_pkg::*; #(
    parameter int DW = 12,
    localparam int CW = DW + 2
) (
    input  logic [DW-1:0]           ta,
    input  logic [DW-1:0]           tb,
    input  logic [DW-1:0]           tc,
    input  logic                    nine,
    output logic [NSEG-1:0][CW-1:0] durs
);
    logic [CW-1:0] ea, eb, ec;
    logic [CW-1:0] a6, a3, a4, b3, b2, c2, mid;

    always_comb begin
        ea = CW'(ta);
        eb = CW'(tb);
        ec = CW'(tc);
        a6 = ea / CW'(6);
        a3 = ea / CW'(3);
        a4 = ea / CW'(4);
        b3 = eb / CW'(3);
        b2 = eb / CW'(2);
        c2 = ec / CW'(2);
        durs = '0;
        if (nine) begin
            mid = (ea - (a6 << 1) - (a3 << 1)) + (eb - (b3 << 1)) + (ec - (c2 << 1));
            durs[0] = a6;
            durs[1] = b3;
            durs[2] = c2;
            durs[3] = a3;
            durs[4] = mid;
            durs[5] = a3;
            durs[6] = c2;
            durs[7] = b3;
            durs[8] = a6;
        end else begin
            mid = (ea - (a4 << 1)) + (eb - (b2 << 1)) + (ec - (c2 << 1));
            durs[0] = a4;
            durs[1] = b2;
            durs[2] = c2;
            durs[3] = mid;
            durs[4] = c2;
            durs[5] = b2;
            durs[6] = a4;
        end
    end
endmodule

// File: rtl/svm_seq_scan.sv
module svm_seq_scan import svm_seq_pkg::*; #(
    parameter int CW = 14
) (
    input  logic [NSEG-1:0][CW-1:0] durs,
    input  logic [SEGW-1:0]         from,
    output logic                    found,
    output logic [SEGW-1:0]         idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NSEG - 1; i >= 0; i--) begin
            if (SEGW'(i) >= from && durs[i] != '0) begin
                found = 1'b1;
                idx   = SEGW'(i);
            end
        end
    end
endmodule

// File: rtl/svm_seq_pattern.sv
module svm_seq_pattern import svm_seq_pkg::*; (
    input  logic [1:0]      tcode,
    input  logic [SEGW-1:0] seg,
    input  logic [2:0]      rot,
    output trip_t           st
);
    logic            nine;
    logic [SEGW-1:0] centre, last;
    logic [2:0]      half;
    trip_t           stage [NROT];

    always_comb begin
        nine   = ~tcode[1];
        centre = nine ? SEGW'(4) : SEGW'(3);
        last   = nine ? SEGW'(8) : SEGW'(6);
        half   = (seg <= centre) ? seg[2:0] : 3'(last - seg);
    end

    assign stage[0] = half_state(tcode, half);

    generate
        for (genvar g = 1; g < NROT; g++) begin : g_rot
            assign stage[g] = rot60(stage[g-1]);
        end
    endgenerate

    assign st = (rot < 3'(NROT)) ? stage[rot] : stage[0];
endmodule

// File: rtl/svm_seq.sv
module svm_seq import svm_seq_pkg::*; #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    tri_code,
    input  logic [2:0]    sector,
    input  logic [DW-1:0] dwell_a,
    input  logic [DW-1:0] dwell_b,
    input  logic [DW-1:0] dwell_c,
    output logic          busy,
    output logic [1:0]    lvl_a,
    output logic [1:0]    lvl_b,
    output logic [1:0]    lvl_c
);
    localparam int CW = DW + 2;

    st_e                     st_q, st_d;
    logic [1:0]              tri_q;
    logic [2:0]              rot_q, rot_in;
    logic [SEGW-1:0]         seg_q;
    logic [CW-1:0]           left_q;
    logic [NSEG-1:0][CW-1:0] dur_q, dur_new;
    trip_t                   lvl_q, pat_out;
    logic                    ld_ok, adv_ok;
    logic [SEGW-1:0]         ld_idx, adv_idx, adv_from;
    logic                    go, advance, done;
    logic [1:0]              pat_tri;
    logic [SEGW-1:0]         pat_seg;
    logic [2:0]              pat_rot;

    assign rot_in   = (sector >= 3'd1 && sector <= 3'd6) ? sector - 3'd1 : 3'd0;
    assign adv_from = seg_q + 1'b1;

    svm_seq_split #(.DW(DW)) u_split (
        .ta(dwell_a), .tb(dwell_b), .tc(dwell_c),
        .nine(~tri_code[1]), .durs(dur_new)
    );

    svm_seq_scan #(.CW(CW)) u_scan_ld (
        .durs(dur_new), .from(SEGW'(0)), .found(ld_ok), .idx(ld_idx)
    );

    svm_seq_scan #(.CW(CW)) u_scan_adv (
        .durs(dur_q), .from(adv_from), .found(adv_ok), .idx(adv_idx)
    );

    always_comb begin
        if (st_q == ST_IDLE) begin
            pat_tri = tri_code;
            pat_seg = ld_idx;
            pat_rot = rot_in;
        end else begin
            pat_tri = tri_q;
            pat_seg = adv_idx;
            pat_rot = rot_q;
        end
    end

    svm_seq_pattern u_pat (
        .tcode(pat_tri), .seg(pat_seg), .rot(pat_rot), .st(pat_out)
    );

    // transitions: GO, STAY_EMPTY, ADVANCE, DONE
    always_comb begin
        go      = 1'b0;
        advance = 1'b0;
        done    = 1'b0;
        st_d    = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start && ld_ok) begin
                    go   = 1'b1;
                    st_d = ST_PLAY;
                end
            end
            ST_PLAY: begin
                if (left_q == '0) begin
                    if (adv_ok) begin
                        advance = 1'b1;
                    end else begin
                        done = 1'b1;
                        st_d = ST_IDLE;
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            seg_q  <= '0;
            left_q <= '0;
            dur_q  <= '0;
            tri_q  <= '0;
            rot_q  <= '0;
        end else begin
            st_q <= st_d;
            if (go) begin
                seg_q  <= ld_idx;
                left_q <= dur_new[ld_idx] - 1'b1;
                dur_q  <= dur_new;
                tri_q  <= tri_code;
                rot_q  <= rot_in;
            end else if (advance) begin
                seg_q  <= adv_idx;
                left_q <= dur_q[adv_idx] - 1'b1;
            end else if (st_q == ST_PLAY && !done) begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (go || advance) begin
            lvl_q <= pat_out;
        end
    end

    assign busy  = (st_q == ST_PLAY);
    assign lvl_a = lvl_q.a;
    assign lvl_b = lvl_q.b;
    assign lvl_c = lvl_q.c;
endmodule

// File: rtl/svm_seq_chk.sv
module svm_seq_chk #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic [DW-1:0] dwell_a,
    input logic [DW-1:0] dwell_b,
    input logic [DW-1:0] dwell_c,
    input logic [1:0]    lvl_a,
    input logic [1:0]    lvl_b,
    input logic [1:0]    lvl_c,
    input logic [3:0]    seg
);
    logic [DW+1:0] len_q, cnt_q;
    logic [5:0]    first_q;
    logic [1:0]    pa, pb, pc;
    logic [3:0]    pseg;
    logic          pbusy;
    logic [2:0]    chg;
    logic          big;

    function automatic logic jump2(logic [1:0] x, logic [1:0] y);
        return (x == 2'b01 && y == 2'b11) || (x == 2'b11 && y == 2'b01);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q   <= '0;
            cnt_q   <= '0;
            first_q <= '0;
            pa      <= '0;
            pb      <= '0;
            pc      <= '0;
            pseg    <= '0;
            pbusy   <= 1'b0;
        end else begin
            if (start && !busy) len_q <= {2'b00, dwell_a} + {2'b00, dwell_b} + {2'b00, dwell_c};
            cnt_q   <= busy ? cnt_q + 1'b1 : '0;
            if (busy && !pbusy) first_q <= {lvl_a, lvl_b, lvl_c};
            pa    <= lvl_a;
            pb    <= lvl_b;
            pc    <= lvl_c;
            pseg  <= seg;
            pbusy <= busy;
        end
    end

    always_comb begin
        chg = {lvl_a != pa, lvl_b != pb, lvl_c != pc};
        big = jump2(lvl_a, pa) || jump2(lvl_b, pb) || jump2(lvl_c, pc);
    end

    p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cnt_q == len_q));

    p_ends_on_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ({lvl_a, lvl_b, lvl_c} == first_q));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !pbusy) |-> ($stable(lvl_a) && $stable(lvl_b) && $stable(lvl_c)));

    p_seg_forward_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pbusy) |-> (seg >= pseg));

    p_one_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pbusy && seg == pseg + 4'd1) |-> ($countones(chg) == 1 && !big));

    p_legal_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_a != 2'b10 && lvl_b != 2'b10 && lvl_c != 2'b10));
endmodule

bind svm_seq svm_seq_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .dwell_a(dwell_a), .dwell_b(dwell_b), .dwell_c(dwell_c),
    .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c), .seg(seg_q)
);

// File: tb/svm_seq_bench.sv
module svm_seq_bench;
    localparam int DW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    tri_code = '0;
    logic [2:0]    sector = 3'd1;
    logic [DW-1:0] dwell_a = '0, dwell_b = '0, dwell_c = '0;
    logic          busy;
    logic [1:0]    lvl_a, lvl_b, lvl_c;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    int qa[$], qb[$], qc[$];
    int ea = 0, eb = 0, ec = 0;
    bit adj_on = 0;
    int pa = 0, pb = 0, pc = 0;
    bit pbusy = 0;

    always #4 clk = ~clk;

    svm_seq #(.DW(DW)) u_svm_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .tri_code(tri_code),
        .sector(sector), .dwell_a(dwell_a), .dwell_b(dwell_b), .dwell_c(dwell_c),
        .busy(busy), .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c)
    );

    function automatic string seq_of(int t);
        case (t)
            0: return "0-- 00- 000 +00 ++0 +00 000 00- 0--";
            1: return "0-- 00- +0- +00 ++0 +00 +0- 00- 0--";
            2: return "0-- +-- +0- +00 +0- +-- 0--";
            default: return "00- +0- ++- ++0 ++- +0- 00-";
        endcase
    endfunction

    function automatic int lvl_at(int t, int s, int ph);
        string q = seq_of(t);
        byte ch = q.getc(s * 4 + ph);
        return (ch == "+") ? 1 : (ch == "-") ? -1 : 0;
    endfunction

    function automatic int seg_len(bit nine, int s, int ta, int tb, int tc);
        int tot = ta + tb + tc;
        if (nine) begin
            case (s)
                0, 8: return ta / 6;
                1, 7: return tb / 3;
                2, 6: return tc / 2;
                3, 5: return ta / 3;
                default: return tot - 2 * (ta / 6 + tb / 3 + tc / 2 + ta / 3);
            endcase
        end
        case (s)
            0, 6: return ta / 4;
            1, 5: return tb / 2;
            2, 4: return tc / 2;
            default: return tot - 2 * (ta / 4 + tb / 2 + tc / 2);
        endcase
    endfunction

    task automatic load_model(int t, int sec, int ta, int tb, int tc);
        bit nine = (t < 2);
        int n = nine ? 9 : 7;
        int k = (sec >= 1 && sec <= 6) ? sec - 1 : 0;
        for (int s = 0; s < n; s++) begin
            int a = lvl_at(t, s, 0);
            int b = lvl_at(t, s, 1);
            int c = lvl_at(t, s, 2);
            int len = seg_len(nine, s, ta, tb, tc);
            for (int r = 0; r < k; r++) begin
                int na = -b;
                int nb = -c;
                int nc = -a;
                a = na; b = nb; c = nc;
            end
            for (int i = 0; i < len; i++) begin
                qa.push_back(a); qb.push_back(b); qc.push_back(c);
            end
        end
    endtask

    task automatic compare();
        int ga = int'($signed(lvl_a));
        int gb = int'($signed(lvl_b));
        int gc = int'($signed(lvl_c));
        bit eby = (qa.size() > 0);
        checks++;
        if (busy !== eby || ga != ea || gb != eb || gc != ec) begin
            errors++;
            $display("FAIL %s: actual busy=%0b lvl=(%0d,%0d,%0d) expected busy=%0b lvl=(%0d,%0d,%0d)",
                     cur_req, busy, ga, gb, gc, eby, ea, eb, ec);
        end
        // R10: on a listed-segment change, one phase moves one step
        if (adj_on && busy && pbusy && (ga != pa || gb != pb || gc != pc)) begin
            int nchg = (ga != pa) + (gb != pb) + (gc != pc);
            int mx = (ga - pa) * (ga - pa) + (gb - pb) * (gb - pb) + (gc - pc) * (gc - pc);
            checks++;
            if (nchg != 1 || mx != 1) begin
                errors++;
                $display("FAIL R10: actual changed=%0d sqstep=%0d expected changed=1 sqstep=1", nchg, mx);
            end
        end
        pa = ga; pb = gb; pc = gc; pbusy = busy;
    endtask

    task automatic step(bit st, int t, int sec, int ta, int tb, int tc);
        start    = st;
        tri_code = 2'(t);
        sector   = 3'(sec);
        dwell_a  = DW'(ta);
        dwell_b  = DW'(tb);
        dwell_c  = DW'(tc);
        @(posedge clk);
        if (qa.size() == 0) begin
            if (st) load_model(t, sec, ta, tb, tc);
        end else begin
            void'(qa.pop_front()); void'(qb.pop_front()); void'(qc.pop_front());
        end
        if (qa.size() > 0) begin
            ea = qa[0]; eb = qb[0]; ec = qc[0];
        end
        @(negedge clk);
        compare();
    endtask

    task automatic run_period(int t, int sec, int ta, int tb, int tc, bit hammer);
        step(1, t, sec, ta, tb, tc);
        while (qa.size() > 0) begin
            if (hammer) step(1, (t + 1) % 4, (sec % 6) + 1, tc, ta, tb);
            else        step(0, t, sec, ta, tb, tc);
        end
        step(0, 3 - t, sec, 5, 5, 5);
        step(0, t, sec, ta, tb, tc);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2: watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        step(0, 0, 1, 0, 0, 0);

        // R3: nine-state lists, sector 1, divisible counts
        adj_on = 1;
        cur_req = "R3";
        run_period(1, 1, 12, 9, 8, 0);
        run_period(0, 1, 6, 6, 4, 0);

        // R4: seven-state lists
        cur_req = "R4";
        run_period(3, 1, 8, 6, 4, 0);
        run_period(2, 1, 8, 6, 4, 0);

        // R5: remainders go to the centre, and the widest counts
        cur_req = "R5";
        run_period(1, 1, 7, 5, 3, 0);
        run_period(3, 1, 7, 5, 3, 0);
        run_period(0, 1, 63, 63, 63, 0);
        run_period(2, 1, 63, 63, 63, 0);

        // R6: rotation through all sector codes
        cur_req = "R6";
        for (int sec = 0; sec < 8; sec++) begin
            for (int t = 0; t < 4; t++) run_period(t, sec, 6, 6, 4, 0);
        end

        // R7: start and new inputs during a period are ignored
        cur_req = "R7";
        run_period(1, 2, 13, 10, 6, 1);
        run_period(2, 5, 9, 7, 5, 1);

        // R2: start held high, back-to-back periods
        cur_req = "R2";
        step(1, 3, 4, 8, 4, 2);
        while (qa.size() > 0) step(1, 3, 4, 8, 4, 2);
        step(1, 0, 3, 6, 3, 2);
        while (qa.size() > 0) step(1, 0, 3, 6, 3, 2);
        step(0, 0, 3, 0, 0, 0);

        // R8: zero-length segments skipped; empty period
        adj_on = 0;
        cur_req = "R8";
        run_period(0, 1, 6, 3, 0, 0);
        run_period(3, 6, 0, 4, 0, 0);
        run_period(1, 1, 1, 1, 1, 0);
        step(1, 2, 1, 0, 0, 0);
        step(0, 2, 1, 0, 0, 0);

        // R9: levels hold over a long idle stretch
        cur_req = "R9";
        run_period(2, 4, 10, 6, 6, 0);
        for (int i = 0; i < 6; i++) step(0, i % 4, 1, 9, 9, 9);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule